// File: doc/BRIEF.md
# Two-Phase Center-Aligned PWM Generator

This block produces two pulse-width-modulated outputs whose pulses sit half a period apart. It is meant to drive the two switches of a push-pull power stage. A prescaled counter runs up from zero to a programmable turning point and then back down to zero. Two compare channels read that counter. One channel, in below-compare mode, places its pulse around count zero. The other, in above-compare mode, places its pulse around the turning point. Because each count value is visited once on the way up and once on the way down, duty changes in steps of two counter ticks.

Each channel holds a shadow compare register and an active compare register. The mode, output enable and polarity inputs act on the pin at once. A single duty input can load both shadow registers together with mirrored values, so that the two phases get the same pulse width. A sticky main output enable gates both pins. A fault input, which may be asynchronous, clears that enable through a two-stage synchroniser. The enable stays clear until it is set again explicitly. The reset input must be asserted asynchronously and released in step with `clk_i` by the surrounding reset tree.

Top module: `pp_pwm_top`

## Requirements
- R1: The counter starts at 0 after reset. On each tick it steps by one, from 0 up to `top_i` and back down to 0. One full period is `2*top_i` ticks. With `top_i` = 0 the counter holds at 0. `cnt_o` never exceeds `top_i` while `top_i` is unchanged.
- R2: With `run_i` high, a counter tick occurs once every `div_m1_i+1` clock cycles. Without a tick, `cnt_o` holds its value. A full period therefore lasts `2*top_i*(div_m1_i+1)` clocks.
- R3: Mode value 0 is the below-compare mode. Counting up, the reference is active while count < compare. Counting down, it is active while count <= compare. A compare value of 0 gives a constant inactive level. A compare value >= `top_i` gives a constant active level. Active time is `2*min(cmp,top)` ticks per period.
- R4: Mode value 1 is the above-compare mode. Counting up, the reference is active while count >= compare. Counting down, it is active while count > compare. Active time is `2*(top-min(cmp,top))` ticks per period.
- R5: A pulse on `duty_wr_i` writes `duty_i>>1` (call it h) into the shadow of channel 0. It writes `top_i-h` into the shadow of channel 1, or 0 when h >= `top_i`. With channel 0 in mode 0 and channel 1 in mode 1, both pins are then active for `2*min(h,top_i)` ticks per period. Channel 0 is active at count 0 and inactive at count `top_i`. Channel 1 is the reverse, whenever 0 < h < `top_i`. If the helper and a direct write arrive in the same cycle, the helper wins.
- R6: `cmp_wr_i[k]` writes `cmp_val_i` into the shadow of channel k. A shadow value moves to the active compare only on the tick that brings the counter to 0. A pulse in progress keeps its old compare value until then.
- R7: While `ch_oe_i[k]` is 0, pin k sits at its inactive level, which equals `ch_pol_i[k]`.
- R8: `ch_pol_i[k]` = 1 inverts pin k, so that its active level is low and its inactive level is high.
- R9: The pins show the waveform only while `moe_o` is 1; otherwise each pin equals its polarity bit. `moe_o` is 0 after reset. It is set by a `moe_set_i` pulse on the next clock edge. A pin follows the counter one clock after the count changes.
- R10: A high `brk_i` clears `moe_o` on the third rising clock edge after it is applied. `moe_o` stays 0 after `brk_i` is released. While the synchronised fault is high, `moe_set_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| run_i | input | 1 | Counter run enable |
| div_m1_i | input | PSC_W | Prescaler ratio minus one |
| top_i | input | CNT_W | Turning point of the up/down counter |
| ch_mode_i | input | 2 | Per-channel mode, 0 below-compare, 1 above-compare |
| ch_oe_i | input | 2 | Per-channel output enable |
| ch_pol_i | input | 2 | Per-channel polarity, 1 = active low |
| cmp_wr_i | input | 2 | Per-channel direct shadow write strobe |
| cmp_val_i | input | CNT_W | Value for direct shadow writes |
| duty_wr_i | input | 1 | Mirrored duty load strobe |
| duty_i | input | CNT_W | Requested duty in counter ticks per period |
| moe_set_i | input | 1 | Sets the main output enable |
| brk_i | input | 1 | Asynchronous fault input, high = fault |
| pwm_o | output | 2 | PWM pins |
| moe_o | output | 1 | Main output enable state |
| cnt_o | output | CNT_W | Current counter value |

## Verification
The bound checker watches, on every clock, the following relations:
- The counter stays inside its range and moves by at most one step.
- The counter moves only on a prescaler tick.
- The active compare values change only on the tick that reaches zero, and that tick always lands on count 0.
- A synchronised fault always clears the enable.
- Disabled channels, and a cleared enable, hold each pin at its polarity level.

Some behaviour only the bench's scenarios can show:
- Pulse widths and period lengths across several turning points and prescaler ratios.
- The half-period phase relation of the two pins.
- The saturation of duty at both extremes.
- Mid-period compare updates being held back until the next zero.
- The exact three-edge fault latency and the stickiness of the cleared enable.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

  localparam int unsigned NCH = 2;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } cnt_dir_e;

  typedef enum logic {
    PM_BELOW = 1'b0,
    PM_ABOVE = 1'b1
  } pwm_mode_e;

endpackage

// File: rtl/pp_pwm_presc.sv
module pp_pwm_presc #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] div_m1_i,
  output logic             tick_o
);

  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);

  logic [PSC_W-1:0] pre_q, pre_d;
  logic             tick;

  always_comb begin
    pre_d = pre_q;
    tick  = en_i && (pre_q >= div_m1_i);
    if (en_i) begin
      if (tick) pre_d = '0;
      else      pre_d = pre_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = tick;

endmodule

// File: rtl/pp_pwm_updown.sv
module pp_pwm_updown
  import pp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output cnt_dir_e         dir_o,
  output logic             reload_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic             reload;

  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    reload = 1'b0;
    if (tick_i) begin
      if (top_i == '0) begin
        cnt_d  = '0;
        dir_d  = DIR_UP;
        reload = 1'b1;
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= top_i) begin
          // turning point lowered below the count: head back down
          cnt_d = cnt_q - ONE;
          dir_d = DIR_DN;
        end else begin
          cnt_d = cnt_q + ONE;
          if ((cnt_q + ONE) == top_i) dir_d = DIR_DN;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d  = '0;
          dir_d  = DIR_UP;
          reload = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_o    = dir_q;
  assign reload_o = reload;

endmodule

// File: rtl/pp_pwm_chan.sv
module pp_pwm_chan
  import pp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  cnt_dir_e         dir_i,
  input  logic             reload_i,
  input  pwm_mode_e        mode_i,
  input  logic             oe_i,
  input  logic             pol_i,
  input  logic             moe_i,
  input  logic             pre_wr_i,
  input  logic [CNT_W-1:0] pre_val_i,
  output logic             pin_o,
  output logic [CNT_W-1:0] cmp_act_o
);

  logic [CNT_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             ref_q, ref_d;

  // shadow and active compare next state
  always_comb begin
    pre_d = pre_q;
    act_d = act_q;
    if (pre_wr_i) pre_d = pre_val_i;
    if (reload_i) act_d = pre_q;
  end

  // reference level from count, direction and mode
  always_comb begin
    ref_d = 1'b0;
    unique case ({mode_i, dir_i})
      {PM_BELOW, DIR_UP}: ref_d = (cnt_i <  act_q);
      {PM_BELOW, DIR_DN}: ref_d = (cnt_i <= act_q);
      {PM_ABOVE, DIR_UP}: ref_d = (cnt_i >= act_q);
      {PM_ABOVE, DIR_DN}: ref_d = (cnt_i >  act_q);
      default:            ref_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      act_q <= '0;
      ref_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
      ref_q <= ref_d;
    end
  end

  assign pin_o     = (moe_i && oe_i) ? (ref_q ^ pol_i) : pol_i;
  assign cmp_act_o = act_q;

endmodule

// File: rtl/pp_pwm_brk.sv
module pp_pwm_brk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic set_i,
  output logic moe_o,
  output logic brk_s_o
);

  logic s1_q, s2_q;
  logic moe_q, moe_d;

  always_comb begin
    moe_d = moe_q;
    if (s2_q)       moe_d = 1'b0;
    else if (set_i) moe_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      moe_q <= 1'b0;
    end else begin
      s1_q  <= brk_i;
      s2_q  <= s1_q;
      moe_q <= moe_d;
    end
  end

  assign moe_o   = moe_q;
  assign brk_s_o = s2_q;

endmodule

// File: rtl/pp_pwm_top.sv
module pp_pwm_top
  import pp_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] div_m1_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [1:0]       ch_mode_i,
  input  logic [1:0]       ch_oe_i,
  input  logic [1:0]       ch_pol_i,
  input  logic [1:0]       cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             moe_set_i,
  input  logic             brk_i,
  output logic [1:0]       pwm_o,
  output logic             moe_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int unsigned CMP_ALL_W = NCH * CNT_W;

  logic                 cnt_tick;
  logic                 reload;
  cnt_dir_e             cnt_dir;
  logic                 brk_sync;
  logic                 moe;
  logic [CNT_W-1:0]     duty_half;
  logic [CNT_W-1:0]     duty_mirror;
  logic [NCH-1:0]       pre_wr;
  logic [CNT_W-1:0]     pre_val [NCH];
  logic [CMP_ALL_W-1:0] cmp_act_all;

  pp_pwm_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (run_i),
    .div_m1_i (div_m1_i),
    .tick_o   (cnt_tick)
  );

  pp_pwm_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cnt_tick),
    .top_i    (top_i),
    .cnt_o    (cnt_o),
    .dir_o    (cnt_dir),
    .reload_o (reload)
  );

  pp_pwm_brk u_brk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .brk_i   (brk_i),
    .set_i   (moe_set_i),
    .moe_o   (moe),
    .brk_s_o (brk_sync)
  );

  // mirrored duty helper: channel 0 gets half, channel 1 its complement
  always_comb begin
    duty_half   = duty_i >> 1;
    duty_mirror = (duty_half >= top_i) ? '0 : (top_i - duty_half);
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      pre_wr[k]  = duty_wr_i | cmp_wr_i[k];
      pre_val[k] = cmp_val_i;
    end
    if (duty_wr_i) begin
      pre_val[0] = duty_half;
      pre_val[1] = duty_mirror;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pp_pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt_o),
      .dir_i     (cnt_dir),
      .reload_i  (reload),
      .mode_i    (pwm_mode_e'(ch_mode_i[k])),
      .oe_i      (ch_oe_i[k]),
      .pol_i     (ch_pol_i[k]),
      .moe_i     (moe),
      .pre_wr_i  (pre_wr[k]),
      .pre_val_i (pre_val[k]),
      .pin_o     (pwm_o[k]),
      .cmp_act_o (cmp_act_all[k*CNT_W +: CNT_W])
    );
  end

  assign moe_o = moe;

endmodule

// File: rtl/pp_pwm_top_chk.sv
module pp_pwm_top_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CNT_W-1:0]   top_i,
  input logic [1:0]         ch_oe_i,
  input logic [1:0]         ch_pol_i,
  input logic [CNT_W-1:0]   cnt_o,
  input logic [1:0]         pwm_o,
  input logic               moe_o,
  input logic               tick_i,
  input logic               reload_i,
  input logic               brk_s_i,
  input logic [2*CNT_W-1:0] cmp_act_i
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o <= top_i) && (top_i != '0) |=> (cnt_o <= top_i) || !$stable(top_i));

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_i != '0) && $stable(top_i) |->
      (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + ONE) || (cnt_o == $past(cnt_o) - ONE));

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));

  p_cmp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> $stable(cmp_act_i));

  p_reload_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_o == '0));

  p_oe0_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_oe_i[0] |-> (pwm_o[0] == ch_pol_i[0]));

  p_oe1_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_oe_i[1] |-> (pwm_o[1] == ch_pol_i[1]));

  p_moe_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !moe_o |-> (pwm_o == ch_pol_i));

  p_brk_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_s_i |=> !moe_o);

endmodule

bind pp_pwm_top pp_pwm_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .top_i     (top_i),
  .ch_oe_i   (ch_oe_i),
  .ch_pol_i  (ch_pol_i),
  .cnt_o     (cnt_o),
  .pwm_o     (pwm_o),
  .moe_o     (moe_o),
  .tick_i    (cnt_tick),
  .reload_i  (reload),
  .brk_s_i   (brk_sync),
  .cmp_act_i (cmp_act_all)
);

// File: tb/pp_pwm_top_tb_top.sv
module pp_pwm_top_tb_top;

  localparam int CNT_W = 16;
  localparam int PSC_W = 16;
  localparam int NV    = 7;

  // stimulus vectors: turning point, prescaler ratio minus one, duty
  localparam int V_TOP [NV] = '{8, 8, 10, 10, 5, 6, 7};
  localparam int V_DIV [NV] = '{0, 1,  0,  0, 2, 0, 0};
  localparam int V_DUTY[NV] = '{8, 6,  0, 25, 3, 12, 1};

  logic             clk;
  logic             rst_n;
  logic             run;
  logic [PSC_W-1:0] div_m1;
  logic [CNT_W-1:0] top;
  logic [1:0]       mode, oe, pol, cwr;
  logic [CNT_W-1:0] cval;
  logic             dwr;
  logic [CNT_W-1:0] duty;
  logic             moe_set;
  logic             brk;
  logic [1:0]       pwm;
  logic             moe;
  logic [CNT_W-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pp_pwm_top #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .run_i     (run),
    .div_m1_i  (div_m1),
    .top_i     (top),
    .ch_mode_i (mode),
    .ch_oe_i   (oe),
    .ch_pol_i  (pol),
    .cmp_wr_i  (cwr),
    .cmp_val_i (cval),
    .duty_wr_i (dwr),
    .duty_i    (duty),
    .moe_set_i (moe_set),
    .brk_i     (brk),
    .pwm_o     (pwm),
    .moe_o     (moe),
    .cnt_o     (cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_enter(input int v);
    int prev;
    prev = int'(cnt);
    forever begin
      @(negedge clk);
      if (int'(cnt) == v && prev != v) break;
      prev = int'(cnt);
    end
  endtask

  task automatic hi_count(input int n, output int ha, output int hb);
    ha = 0;
    hb = 0;
    repeat (n) begin
      @(negedge clk);
      ha += int'(pwm[0]);
      hb += int'(pwm[1]);
    end
  endtask

  task automatic period_len(input int v, output int len);
    int prev;
    wait_enter(v);
    prev = v;
    len  = 0;
    forever begin
      @(negedge clk);
      len++;
      if (int'(cnt) == v && prev != v) break;
      prev = int'(cnt);
    end
  endtask

  task automatic load_duty(input int d);
    @(negedge clk);
    duty = CNT_W'(d);
    dwr  = 1'b1;
    @(negedge clk);
    dwr  = 1'b0;
  endtask

  task automatic write_cmp(input int k, input int v);
    @(negedge clk);
    cval   = CNT_W'(v);
    cwr[k] = 1'b1;
    @(negedge clk);
    cwr    = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ha, hb, len, per, half, hi;
    rst_n = 1'b0; run = 1'b0; div_m1 = '0; top = '0;
    mode = 2'b10; oe = 2'b11; pol = 2'b00; cwr = 2'b00; cval = '0;
    dwr = 1'b0; duty = '0; moe_set = 1'b0; brk = 1'b0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1", "count in reset", int'(cnt), 0);
    chk("R9", "enable in reset", int'(moe), 0);
    chk("R9", "pins in reset", int'(pwm), 0);
    rst_n = 1'b1;

    // enable still clear: no pulses reach the pins
    top = 16'd8; run = 1'b1;
    load_duty(8);
    repeat (48) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R9", "ch0 high without enable", ha, 0);
    chk("R9", "ch1 high without enable", hb, 0);
    @(negedge clk) moe_set = 1'b1;
    @(negedge clk) moe_set = 1'b0;
    chk("R9", "enable after set", int'(moe), 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      top    = CNT_W'(V_TOP[i]);
      div_m1 = PSC_W'(V_DIV[i]);
      load_duty(V_DUTY[i]);
      per  = 2 * V_TOP[i] * (V_DIV[i] + 1);
      half = V_DUTY[i] / 2;
      hi   = 2 * ((half < V_TOP[i]) ? half : V_TOP[i]) * (V_DIV[i] + 1);
      repeat (3 * per + 4) @(negedge clk);
      period_len(V_TOP[i], len);
      chk("R2", $sformatf("period clocks vec%0d", i), len, per);
      hi_count(per, ha, hb);
      chk("R5", $sformatf("ch0 high clocks vec%0d", i), ha, hi);
      chk("R5", $sformatf("ch1 high clocks vec%0d", i), hb, hi);
      if (half > 0 && half < V_TOP[i]) begin
        wait_enter(0);
        @(negedge clk);
        chk("R5", $sformatf("pins at count 0 vec%0d", i), int'(pwm), 1);
        wait_enter(V_TOP[i]);
        @(negedge clk);
        chk("R5", $sformatf("pins at turning point vec%0d", i), int'(pwm), 2);
      end
    end

    // R1: turning point 0 keeps the count at zero
    top = '0;
    repeat (6) @(negedge clk);
    chk("R1", "count with top 0", int'(cnt), 0);

    // R6: mid-period update held until zero (top 8, ratio 4, period 64)
    top = 16'd8; div_m1 = 16'd3;
    load_duty(8);
    repeat (140) @(negedge clk);
    wait_enter(8);
    load_duty(0);
    wait_enter(2);
    @(negedge clk);
    chk("R6", "ch0 keeps old compare on way down", int'(pwm[0]), 1);
    wait_enter(0);
    wait_enter(2);
    @(negedge clk);
    chk("R6", "ch0 uses new compare after zero", int'(pwm[0]), 0);

    // R3/R4/R6: direct writes and mode selection, top 8, ratio 1
    div_m1 = '0;
    write_cmp(0, 3);
    write_cmp(1, 2);
    repeat (40) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R3", "ch0 below mode cmp 3", ha, 6);
    chk("R6", "ch1 direct write cmp 2", hb, 12);
    mode = 2'b11;
    repeat (4) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R4", "ch0 above mode cmp 3", ha, 10);
    mode = 2'b00;
    repeat (4) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R3", "ch1 below mode cmp 2", hb, 4);
    mode = 2'b10;

    // R8: polarity inversion
    pol = 2'b01;
    repeat (4) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R8", "ch0 inverted high clocks", ha, 10);
    chk("R8", "ch1 unaffected", hb, 12);

    // R7: output enable off holds the inactive level
    pol = 2'b00; oe = 2'b01;
    repeat (4) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R7", "ch1 disabled low", hb, 0);
    chk("R7", "ch0 still running", ha, 6);
    pol = 2'b10;
    repeat (2) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R7", "ch1 disabled idle high", hb, 16);
    pol = 2'b00; oe = 2'b11;

    // R10: fault latency, stickiness and priority over set
    @(negedge clk) brk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "enable before third edge", int'(moe), 1);
    @(negedge clk);
    chk("R10", "enable after third edge", int'(moe), 0);
    brk = 1'b0;
    repeat (6) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R10", "sticky clear ch0", ha, 0);
    chk("R10", "sticky clear ch1", hb, 0);
    brk = 1'b1;
    repeat (4) @(negedge clk);
    moe_set = 1'b1;
    @(negedge clk) moe_set = 1'b0;
    chk("R10", "set ignored during fault", int'(moe), 0);
    brk = 1'b0;
    repeat (4) @(negedge clk);
    moe_set = 1'b1;
    @(negedge clk) moe_set = 1'b0;
    chk("R9", "enable restored", int'(moe), 1);
    repeat (2) @(negedge clk);
    hi_count(16, ha, hb);
    chk("R9", "ch0 pulses after restore", ha, 6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule